// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit carries out a multi-register transfer between a 16-entry register file and word-addressed memory. A single start pulse hands it a register mask, a base address, a two-bit addressing mode, a direction (load or store), a base-update bit and a status-restore bit. It counts the registers named in the mask and works out the first address from that count and the mode. It then issues one 32-bit word access per clock, walking the mask from the lowest register index upward, with the address rising by 4 for each access.

On each access cycle the sequencer drives the register index, the byte address and the direction. For a store it forwards the register file's read data to memory. For a load it forwards the memory's read data to the register file with a write strobe. One cycle after the last access it raises a done pulse. With that pulse it offers the updated base value and its write strobe, a flag saying the program counter (register 15) was loaded together with the loaded word, and a flag asking for the saved status word to be copied into the current one. The register file and the memory lie outside the block. Both answer combinationally in the access cycle.

The controller has three states. IDLE waits for start. XFER issues one access per cycle. FIN raises done for one cycle. The transitions are: IDLE to XFER on start with a non-empty mask (called LAUNCH), IDLE to FIN on start with an empty mask (called SKIP), XFER to XFER while more than one register remains (called STEP), XFER to FIN after the last register (called DRAIN), and FIN to IDLE unconditionally (called RETIRE).

Top module: `blk_xfer_seq`

## Requirements
- R1: The number of access cycles (acc_valid high) equals the number of set bits in reg_list, and these cycles are consecutive, beginning the cycle after start is sampled.
- R2: With addr_mode 0 (increment-after) the first access address is base_addr. With addr_mode 1 (increment-before) it is base_addr + 4.
- R3: With addr_mode 2 (decrement-after) the first address is base_addr - 4*n + 4. With addr_mode 3 (decrement-before) it is base_addr - 4*n, where n is the set-bit count.
- R4: Registers are accessed in strictly ascending index order (bit i of reg_list is register i), and the address rises by 4 from one access to the next.
- R5: wb_we is high only in the done cycle, and only when wb_en was set at start.
- R6: In the done cycle wb_val is base_addr + 4*n for modes 0 and 1, and base_addr - 4*n for modes 2 and 3.
- R7: For a load whose mask includes bit 15, pc_load is high in the done cycle and pc_value equals the word read for register 15. For a store, or a mask without bit 15, pc_load stays low.
- R8: status_restore is high in the done cycle only for a load with psr_restore set and bit 15 in the mask.
- R9: acc_user_bank is high on every access when psr_restore is set and the transfer is either a store or a load without bit 15. Otherwise it is low.
- R10: done is a one-cycle pulse in the cycle after the last access. An empty mask gives done in the cycle after start, with no access.
- R11: busy is high from the cycle after start through the done cycle. A start pulse while busy has no effect on the running transfer.
- R12: On a store access acc_write is 1 and acc_wdata equals rf_rdata. On a load access rf_we is 1 and rf_wdata equals mem_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled in IDLE only) |
| reg_list | input | 16 | Register mask, bit i selects register i |
| base_addr | input | 32 | Base byte address |
| addr_mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| is_load | input | 1 | 1 load from memory, 0 store to memory |
| wb_en | input | 1 | Request base writeback |
| psr_restore | input | 1 | Status-restore / user-bank bit |
| rf_rdata | input | 32 | Register file read data for acc_idx |
| mem_rdata | input | 32 | Memory read data for acc_addr |
| busy | output | 1 | Transfer in progress |
| acc_valid | output | 1 | Memory access this cycle |
| acc_write | output | 1 | Access is a memory write |
| acc_idx | output | 4 | Register index of this access |
| acc_addr | output | 32 | Byte address of this access |
| acc_wdata | output | 32 | Memory write data |
| acc_user_bank | output | 1 | Use the user-mode register bank |
| rf_we | output | 1 | Register file write strobe |
| rf_wdata | output | 32 | Register file write data |
| done | output | 1 | One-cycle completion pulse |
| wb_we | output | 1 | Base register write strobe |
| wb_val | output | 32 | Updated base address |
| pc_load | output | 1 | Program counter was loaded |
| pc_value | output | 32 | Word loaded for register 15 |
| status_restore | output | 1 | Copy saved status to current status |

## Verification
The assertions assume that rst_n is held low for at least one clock edge before use. They also assume the mask and control inputs matter only in the cycle start is sampled in IDLE. Beyond that, the properties make no assumption about start timing, since the block must ignore start while busy. The stimulus drives every input at the falling edge, raises start for exactly one cycle per transfer, and deliberately pulses start again mid-transfer with a different mask to exercise that case. The memory and register file answer with data derived from the address and the index, so every forwarded word is predictable.

// File: rtl/bxs_pkg.sv
`timescale 1ns/1ps
package bxs_pkg;
    typedef enum logic [1:0] {
        AM_INC_AFTER  = 2'd0,
        AM_INC_BEFORE = 2'd1,
        AM_DEC_AFTER  = 2'd2,
        AM_DEC_BEFORE = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/bxs_popcount.sv
`timescale 1ns/1ps
module bxs_popcount #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/bxs_low_pick.sv
`timescale 1ns/1ps
module bxs_low_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot,
    output logic          last
);
    logic [IW-1:0] term [N];

    assign onehot = vec & (~vec + N'(1));
    assign last   = ((vec & ~onehot) == '0);

    for (genvar g = 0; g < N; g++) begin : g_term
        assign term[g] = onehot[g] ? IW'(g) : '0;
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            idx = idx | term[i];
        end
    end
endmodule

// File: rtl/bxs_addr_calc.sv
`timescale 1ns/1ps
module bxs_addr_calc
    import bxs_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0] base,
    input  addr_mode_e    mode,
    input  logic [CW-1:0] cnt,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] new_base
);
    localparam int          BSH  = $clog2(WORD_BYTES);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [AW-1:0] span;
    assign span = AW'(cnt) << BSH;

    always_comb begin
        unique case (mode)
            AM_INC_AFTER: begin
                first_addr = base;
                new_base   = base + span;
            end
            AM_INC_BEFORE: begin
                first_addr = base + STEP;
                new_base   = base + span;
            end
            AM_DEC_AFTER: begin
                first_addr = base - span + STEP;
                new_base   = base - span;
            end
            AM_DEC_BEFORE: begin
                first_addr = base - span;
                new_base   = base - span;
            end
            default: begin
                first_addr = base;
                new_base   = base;
            end
        endcase
    end
endmodule

// File: rtl/blk_xfer_seq.sv
`timescale 1ns/1ps
module blk_xfer_seq
    import bxs_pkg::*;
#(
    parameter int NREG       = 16,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [NREG-1:0]         reg_list,
    input  logic [AW-1:0]           base_addr,
    input  logic [1:0]              addr_mode,
    input  logic                    is_load,
    input  logic                    wb_en,
    input  logic                    psr_restore,
    input  logic [DW-1:0]           rf_rdata,
    input  logic [DW-1:0]           mem_rdata,
    output logic                    busy,
    output logic                    acc_valid,
    output logic                    acc_write,
    output logic [$clog2(NREG)-1:0] acc_idx,
    output logic [AW-1:0]           acc_addr,
    output logic [DW-1:0]           acc_wdata,
    output logic                    acc_user_bank,
    output logic                    rf_we,
    output logic [DW-1:0]           rf_wdata,
    output logic                    done,
    output logic                    wb_we,
    output logic [AW-1:0]           wb_val,
    output logic                    pc_load,
    output logic [DW-1:0]           pc_value,
    output logic                    status_restore
);
    localparam int            IW     = $clog2(NREG);
    localparam int            CW     = $clog2(NREG + 1);
    localparam int            PC_IDX = NREG - 1;
    localparam logic [AW-1:0] STEP   = AW'(WORD_BYTES);

    seq_state_e    state_q, state_d;
    logic [NREG-1:0] mask_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   wbval_q;
    logic [DW-1:0]   pcval_q;
    logic            load_q, wb_q, srs_q, pc_in_q;

    logic [CW-1:0]   set_cnt;
    logic [AW-1:0]   first_addr, new_base;
    logic [IW-1:0]   cur_idx;
    logic [NREG-1:0] cur_onehot;
    logic            cur_last;
    logic            launch;

    bxs_popcount #(.N(NREG), .CW(CW)) u_cnt (
        .vec (reg_list),
        .cnt (set_cnt)
    );

    bxs_addr_calc #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_addr (
        .base       (base_addr),
        .mode       (addr_mode_e'(addr_mode)),
        .cnt        (set_cnt),
        .first_addr (first_addr),
        .new_base   (new_base)
    );

    bxs_low_pick #(.N(NREG), .IW(IW)) u_pick (
        .vec    (mask_q),
        .idx    (cur_idx),
        .onehot (cur_onehot),
        .last   (cur_last)
    );

    assign launch = (state_q == ST_IDLE) && start;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (|reg_list) ? ST_XFER : ST_FIN;
            ST_XFER: if (cur_last) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            addr_q  <= '0;
            wbval_q <= '0;
            pcval_q <= '0;
            load_q  <= 1'b0;
            wb_q    <= 1'b0;
            srs_q   <= 1'b0;
            pc_in_q <= 1'b0;
        end else if (launch) begin
            mask_q  <= reg_list;
            addr_q  <= first_addr;
            wbval_q <= new_base;
            pcval_q <= '0;
            load_q  <= is_load;
            wb_q    <= wb_en;
            srs_q   <= psr_restore;
            pc_in_q <= reg_list[PC_IDX];
        end else if (state_q == ST_XFER) begin
            mask_q <= mask_q & ~cur_onehot;
            addr_q <= addr_q + STEP;
            if (load_q && (cur_idx == IW'(PC_IDX))) begin
                pcval_q <= mem_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        busy           = (state_q != ST_IDLE);
        acc_valid      = (state_q == ST_XFER);
        acc_write      = acc_valid && !load_q;
        acc_idx        = acc_valid ? cur_idx : '0;
        acc_addr       = acc_valid ? addr_q : '0;
        acc_wdata      = acc_write ? rf_rdata : '0;
        acc_user_bank  = acc_valid && srs_q && !(load_q && pc_in_q);
        rf_we          = acc_valid && load_q;
        rf_wdata       = rf_we ? mem_rdata : '0;
        done           = (state_q == ST_FIN);
        wb_we          = done && wb_q;
        wb_val         = wbval_q;
        pc_load        = done && load_q && pc_in_q;
        pc_value       = pcval_q;
        status_restore = pc_load && srs_q;
    end
endmodule

// File: rtl/bxs_checker.sv
`timescale 1ns/1ps
module bxs_checker #(
    parameter int IW = 4,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          acc_valid,
    input logic [IW-1:0] acc_idx,
    input logic [AW-1:0] acc_addr,
    input logic          acc_user_bank,
    input logic          wb_we,
    input logic          pc_load,
    input logic          status_restore
);
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && $past(acc_valid)) |-> (acc_addr == $past(acc_addr) + AW'(4)));

    p_idx_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && $past(acc_valid)) |-> (acc_idx > $past(acc_idx)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_no_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !acc_valid);

    p_busy_until_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_access_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> busy);

    p_wb_in_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |-> done);

    p_restore_needs_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status_restore |-> pc_load);

    p_pc_in_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> done);

    p_user_on_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_user_bank |-> acc_valid);
endmodule

bind blk_xfer_seq bxs_checker #(.IW($clog2(NREG)), .AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy           (busy),
    .done           (done),
    .acc_valid      (acc_valid),
    .acc_idx        (acc_idx),
    .acc_addr       (acc_addr),
    .acc_user_bank  (acc_user_bank),
    .wb_we          (wb_we),
    .pc_load        (pc_load),
    .status_restore (status_restore)
);

// File: tb/blk_xfer_seq_tb.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] reg_list = '0;
    logic [31:0] base_addr = '0;
    logic [1:0]  addr_mode = '0;
    logic        is_load = 1'b0, wb_en = 1'b0, psr_restore = 1'b0;
    logic [31:0] rf_rdata, mem_rdata;
    logic        busy, acc_valid, acc_write, acc_user_bank, rf_we, done, wb_we, pc_load, status_restore;
    logic [3:0]  acc_idx;
    logic [31:0] acc_addr, acc_wdata, rf_wdata, wb_val, pc_value;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [31:0] MEM_KEY = 32'hA5A5_0000;

    always #10 clk = ~clk;

    assign mem_rdata = acc_addr ^ MEM_KEY;
    assign rf_rdata  = 32'hC0DE_0000 | {28'd0, acc_idx};

    blk_xfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list),
        .base_addr(base_addr), .addr_mode(addr_mode), .is_load(is_load),
        .wb_en(wb_en), .psr_restore(psr_restore), .rf_rdata(rf_rdata),
        .mem_rdata(mem_rdata), .busy(busy), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_idx(acc_idx), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_user_bank(acc_user_bank), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .done(done), .wb_we(wb_we), .wb_val(wb_val),
        .pc_load(pc_load), .pc_value(pc_value), .status_restore(status_restore)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model: expected sequence built behaviourally, compared each clock.
    task automatic run_xfer(input logic [15:0] lst, input logic [31:0] base,
                            input int mode, input bit ld, input bit wb,
                            input bit srs, input bit poke);
        int q_idx[$];
        int n;
        logic [31:0] a, wbexp, pcexp;
        bit user_exp, pc_exp;
        for (int i = 0; i < 16; i++) if (lst[i]) q_idx.push_back(i);
        n = q_idx.size();
        case (mode)
            0: a = base;
            1: a = base + 32'd4;
            2: a = base - 32'(4 * n) + 32'd4;
            default: a = base - 32'(4 * n);
        endcase
        wbexp    = (mode < 2) ? base + 32'(4 * n) : base - 32'(4 * n);
        pc_exp   = ld && lst[15];
        user_exp = srs && !(ld && lst[15]);
        pcexp    = '0;

        @(negedge clk);
        reg_list = lst; base_addr = base; addr_mode = 2'(mode);
        is_load = ld; wb_en = wb; psr_restore = srs; start = 1'b1;
        @(posedge clk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            start = 1'b0;
            chk("R1 acc_valid", {31'd0, acc_valid}, 32'd1);
            chk("R11 busy during access", {31'd0, busy}, 32'd1);
            chk("R4 acc_idx order", {28'd0, acc_idx}, 32'(q_idx[k]));
            chk(k == 0 ? (mode < 2 ? "R2 first addr" : "R3 first addr") : "R4 addr step",
                acc_addr, a);
            chk("R9 user bank", {31'd0, acc_user_bank}, {31'd0, user_exp});
            chk("R12 direction", {31'd0, acc_write}, {31'd0, !ld});
            if (ld) begin
                chk("R12 rf_we", {31'd0, rf_we}, 32'd1);
                chk("R12 rf_wdata", rf_wdata, a ^ MEM_KEY);
                if (q_idx[k] == 15) pcexp = a ^ MEM_KEY;
            end else begin
                chk("R12 acc_wdata", acc_wdata, 32'hC0DE_0000 | 32'(q_idx[k]));
            end
            if (poke && k == 0) begin
                // R11: start while busy with a different request must be ignored
                reg_list = 16'h0001; base_addr = 32'hDEAD_0000; start = 1'b1;
            end
            a = a + 32'd4;
        end
        @(negedge clk);
        start = 1'b0;
        chk("R10 done after last", {31'd0, done}, 32'd1);
        chk("R1 no extra access", {31'd0, acc_valid}, 32'd0);
        chk("R11 busy in done", {31'd0, busy}, 32'd1);
        chk("R5 wb_we", {31'd0, wb_we}, {31'd0, wb});
        if (wb) chk("R6 wb_val", wb_val, wbexp);
        chk("R7 pc_load", {31'd0, pc_load}, {31'd0, pc_exp});
        if (pc_exp) chk("R7 pc_value", pc_value, pcexp);
        chk("R8 status_restore", {31'd0, status_restore}, {31'd0, pc_exp && srs});
        @(negedge clk);
        chk("R10 done one cycle", {31'd0, done}, 32'd0);
        chk("R11 idle after done", {31'd0, busy}, 32'd0);
        chk("R5 wb_we after done", {31'd0, wb_we}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset busy", {31'd0, busy}, 32'd0);
        chk("R10 reset done", {31'd0, done}, 32'd0);
        chk("R1 reset acc_valid", {31'd0, acc_valid}, 32'd0);
        rst_n = 1'b1;
        run_xfer(16'h00F1, 32'h0000_1000, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        run_xfer(16'h8421, 32'h0000_2000, 1, 1'b0, 1'b0, 1'b1, 1'b0);
        run_xfer(16'h8003, 32'h0000_3000, 2, 1'b1, 1'b1, 1'b1, 1'b0);
        run_xfer(16'hFFFF, 32'h0000_4000, 3, 1'b0, 1'b1, 1'b0, 1'b1);
        run_xfer(16'h0000, 32'h0000_5000, 1, 1'b1, 1'b1, 1'b0, 1'b0);
        run_xfer(16'h0006, 32'h0000_6000, 2, 1'b1, 1'b0, 1'b1, 1'b1);
        run_xfer(16'h8010, 32'h0000_7000, 3, 1'b1, 1'b1, 1'b0, 1'b0);
        run_xfer(16'h8000, 32'h0000_0004, 0, 1'b0, 1'b1, 1'b1, 1'b0);
        run_xfer(16'h0001, 32'h0000_0000, 3, 1'b1, 1'b1, 1'b0, 1'b0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule